// File: doc/BRIEF.md
# 100BASE-TX Transmit Symbol Encoder

This block turns the nibble stream that a MAC presents on its media-independent transmit interface into the serial, scrambled, three-level symbol stream of a 100 Mbps twisted-pair line. The block runs on the bit-time clock. A bit-enable strobe marks each 125 MHz bit time, so gaps in the strobe freeze the whole pipeline. Every five bit times the block samples one nibble. It maps the nibble to a five-bit code group and shifts the group out most significant bit first. Each bit is XORed with an 11-bit LFSR keystream, and the result drives a three-level line coder.

Framing is handled in the code-group domain. The first two nibbles of a frame become the start-delimiter pair (J then K). Later nibbles use the data table. A nibble flagged as an error becomes the halt group. When the enable drops, the frame closes with the end-delimiter pair (T then R). Idle groups (all ones) fill the time between frames. An output flag announces the bit time at which the next nibble is taken, so the MAC side can pace itself.

Top module: `tx100_sym_encoder`

## Requirements
- R1: While `rst` is high and after its last cycle, `line_sym` is 0, `sym_stb` is 0 and `nib_req` is 0. After reset the first code group sent is idle.
- R2: While no frame is open, each code group is the idle group 11111.
- R3: A code group boundary that sees `tx_en` high while no frame is open sends J (11000). The next group is always K (10001), whatever the inputs are at that boundary.
- R4: Inside a frame, a boundary with `tx_en` high and `tx_er` low sends the data group of `txd`. The groups for 0..F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: Inside a frame, a boundary with `tx_en` and `tx_er` both high sends H (00100) instead of the data group.
- R6: Inside a frame, a boundary with `tx_en` low sends T (01101). The next group is R (00111) regardless of the inputs, and the boundary after R may open a new frame.
- R7: Each code group lasts five bit times and is sent MSB first. The inputs are sampled only at the bit time that follows a cycle with `nib_req` high. `nib_req` is high exactly when the next bit time is the last bit of the current group.
- R8: Each code bit is XORed with the key bit s[10]^s[8] of an 11-bit register `s` that starts at SEED. The register shifts left once per bit time, with the key bit entering at s[0].
- R9: A scrambled 1 moves the line level one step around the cycle 0, +1, 0, -1. A scrambled 0 keeps the level. `line_sym` carries the level in two's complement: 00 = 0, 01 = +1, 11 = -1.
- R10: A cycle with `bit_en` low changes no output and no state. The bit stream then resumes exactly where it stopped.
- R11: `sym_stb` is high in the cycle after each cycle in which `bit_en` was high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Advances one line bit time |
| tx_en | input | 1 | Frame enable from the MAC |
| tx_er | input | 1 | Error flag for the current nibble |
| txd | input | 4 | Transmit nibble |
| nib_req | output | 1 | Next bit time samples the MAC inputs |
| line_sym | output | 2 | Signed three-level line symbol |
| sym_stb | output | 1 | `line_sym` was updated in this cycle |

## Verification
A framing state that goes wrong shows up within one code group: a wrong or missing delimiter, or a data group where idle belongs, changes the scrambled bits and therefore the line levels in the next five bit times. A keystream register that is off by even one step corrupts the level sequence from that bit onward. The line coder's phase and level carry the error forward, so it never clears by itself. A group counter that slips moves `nib_req` and the sampling point immediately. The bench compares every cycle against a behavioural model, so each of these faults is caught within a handful of cycles of its cause.

// File: rtl/tx100_pkg.sv
package tx100_pkg;
  localparam int GRP_W = 5;
  typedef logic [GRP_W-1:0] cgrp_t;

  localparam cgrp_t CG_IDLE = 5'b11111;
  localparam cgrp_t CG_J    = 5'b11000;
  localparam cgrp_t CG_K    = 5'b10001;
  localparam cgrp_t CG_T    = 5'b01101;
  localparam cgrp_t CG_R    = 5'b00111;
  localparam cgrp_t CG_H    = 5'b00100;

  typedef enum logic [1:0] {FS_IDLE, FS_SEND_K, FS_DATA, FS_SEND_R} fstate_t;

  function automatic cgrp_t data_grp(input logic [3:0] n);
    cgrp_t g;
    case (n)
      4'h0: g = 5'b11110;  4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;  4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;  4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;  4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;  4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;  4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;  4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;  default: g = 5'b11101;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/tx100_grp_framer.sv
module tx100_grp_framer
  import tx100_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] txd,
  output logic             nib_req,
  output logic             ser_bit
);
  localparam int BC_W = $clog2(GRP_W);
  localparam logic [BC_W-1:0] LAST = BC_W'(GRP_W - 1);

  logic [BC_W-1:0] bc;
  cgrp_t           sreg, nxt_grp;
  fstate_t         st, nxt_st;

  always_comb begin
    nxt_grp = CG_IDLE;
    nxt_st  = st;
    case (st)
      FS_IDLE: if (tx_en) begin
        nxt_grp = CG_J;
        nxt_st  = FS_SEND_K;
      end
      FS_SEND_K: begin
        nxt_grp = CG_K;
        nxt_st  = FS_DATA;
      end
      FS_DATA: if (tx_en) begin
        nxt_grp = tx_er ? CG_H : data_grp(txd[3:0]);
      end else begin
        nxt_grp = CG_T;
        nxt_st  = FS_SEND_R;
      end
      default: begin
        nxt_grp = CG_R;
        nxt_st  = FS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bc      <= '0;
      sreg    <= CG_IDLE;
      st      <= FS_IDLE;
      nib_req <= 1'b0;
    end else if (bit_en) begin
      if (bc == LAST) begin
        bc      <= '0;
        sreg    <= nxt_grp;
        st      <= nxt_st;
        nib_req <= 1'b0;
      end else begin
        bc      <= bc + 1'b1;
        sreg    <= {sreg[GRP_W-2:0], 1'b0};
        nib_req <= (bc == LAST - 1'b1);
      end
    end
  end

  assign ser_bit = sreg[GRP_W-1];

  // R7
  bc_range_chk: assert property (@(posedge clk) disable iff (rst) bc <= LAST);
  // R3
  start_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st == FS_SEND_K) |-> sreg == CG_J);
  // R6
  end_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st == FS_SEND_R) |-> sreg == CG_T);
endmodule

// File: rtl/tx100_scrambler.sv
module tx100_scrambler #(
  parameter int           LFSR_W = 11,
  parameter int           TAP    = 8,
  parameter logic [10:0]  SEED   = 11'h5A5
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic din,
  output logic dout
);
  logic [LFSR_W-1:0] lfsr;
  logic              key;

  assign key  = lfsr[LFSR_W-1] ^ lfsr[TAP];
  assign dout = din ^ key;

  always_ff @(posedge clk) begin
    if (rst)         lfsr <= LFSR_W'(SEED);
    else if (bit_en) lfsr <= {lfsr[LFSR_W-2:0], key};
  end

  // R8
  lfsr_nz_chk: assert property (@(posedge clk) disable iff (rst) lfsr != '0);
  // R10
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(lfsr));
endmodule

// File: rtl/tx100_mlt3.sv
module tx100_mlt3 (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       din,
  output logic [1:0] line_sym,
  output logic       sym_stb
);
  logic [1:0] ph, nxt_ph, lvl;

  assign nxt_ph = din ? ph + 2'd1 : ph;

  always_comb begin
    case (nxt_ph)
      2'd1:    lvl = 2'b01;
      2'd3:    lvl = 2'b11;
      default: lvl = 2'b00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= 2'd0;
      line_sym <= 2'b00;
      sym_stb  <= 1'b0;
    end else begin
      sym_stb <= bit_en;
      if (bit_en) begin
        ph       <= nxt_ph;
        line_sym <= lvl;
      end
    end
  end

  // R9
  level_code_chk: assert property (@(posedge clk) disable iff (rst) line_sym != 2'b10);
  // R9
  level_step_chk: assert property (@(posedge clk) disable iff (rst)
    (line_sym != 2'b00) |=> (line_sym == $past(line_sym) || line_sym == 2'b00));
  // R10
  stb_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_sym) |-> sym_stb);
endmodule

// File: rtl/tx100_sym_encoder.sv
module tx100_sym_encoder #(
  parameter int          NIB_W  = 4,
  parameter int          LFSR_W = 11,
  parameter int          TAP    = 8,
  parameter logic [10:0] SEED   = 11'h5A5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] txd,
  output logic             nib_req,
  output logic [1:0]       line_sym,
  output logic             sym_stb
);
  logic code_bit, scr_bit;

  tx100_grp_framer #(.NIB_W(NIB_W)) u_framer (
    .clk(clk), .rst(rst), .bit_en(bit_en), .tx_en(tx_en), .tx_er(tx_er),
    .txd(txd), .nib_req(nib_req), .ser_bit(code_bit)
  );

  tx100_scrambler #(.LFSR_W(LFSR_W), .TAP(TAP), .SEED(SEED)) u_scr (
    .clk(clk), .rst(rst), .bit_en(bit_en), .din(code_bit), .dout(scr_bit)
  );

  tx100_mlt3 u_mlt3 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .din(scr_bit),
    .line_sym(line_sym), .sym_stb(sym_stb)
  );
endmodule

// File: tb/tx100_sym_encoder_test.sv
module tx100_sym_encoder_test;
  localparam logic [10:0] SEED = 11'h5A5;

  logic clk = 1'b0, rst = 1'b1, bit_en = 1'b0, tx_en = 1'b0, tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic nib_req, sym_stb;
  logic [1:0] line_sym;

  always #5 clk = ~clk;

  tx100_sym_encoder #(.SEED(SEED)) uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .tx_en(tx_en), .tx_er(tx_er),
    .txd(txd), .nib_req(nib_req), .line_sym(line_sym), .sym_stb(sym_stb)
  );

  int checks = 0, fails = 0, gap_mode = 0, gctr = 0;
  string cur_tag = "R2";
  bit finished = 0;

  // behavioural reference model
  int mq[$];
  logic [10:0] mlfsr;
  int mph = 0, mst = 0, exp_sym = 0, mb = 0, mg = 0;
  bit exp_stb = 0, m_loaded = 0, mk = 0, ms = 0;

  function automatic int tbl(int n);
    int t[16] = '{30, 9, 20, 21, 10, 11, 14, 15, 18, 19, 22, 23, 26, 27, 28, 29};
    return t[n];
  endfunction

  function automatic void push_grp(int g);
    for (int i = 4; i >= 0; i--) mq.push_back((g >> i) & 1);
  endfunction

  always @(posedge clk) begin
    m_loaded = 0;
    if (rst) begin
      mq.delete(); push_grp(31);
      mlfsr = SEED; mph = 0; exp_sym = 0; exp_stb = 0; mst = 0;
    end else begin
      exp_stb = bit_en;
      if (bit_en) begin
        mb = mq.pop_front();
        mk = mlfsr[10] ^ mlfsr[8];
        mlfsr = {mlfsr[9:0], mk};
        ms = mb[0] ^ mk;
        if (ms) mph = (mph + 1) % 4;
        exp_sym = (mph == 1) ? 1 : (mph == 3) ? -1 : 0;
        if (mq.size() == 0) begin
          if (mst == 0) begin
            if (tx_en) begin mg = 24; mst = 1; end else mg = 31;
          end else if (mst == 1) begin
            mg = 17; mst = 2;
          end else if (mst == 2) begin
            if (tx_en) mg = tx_er ? 4 : tbl(int'(txd));
            else begin mg = 13; mst = 3; end
          end else begin
            mg = 7; mst = 0;
          end
          push_grp(mg);
          m_loaded = 1;
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    gctr++;
    bit_en = (gap_mode == 0) ? 1'b1 : ((gctr % 3) != 1);
  end

  // R8 R9: every line level comparison exercises the keystream and line coding
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(int'($signed(line_sym)) == exp_sym, {cur_tag, " R8 R9"}, "line_sym",
          int'($signed(line_sym)), exp_sym);
      chk(sym_stb == exp_stb, "R11", "sym_stb", int'(sym_stb), int'(exp_stb));
      chk(nib_req == (mq.size() == 1), "R7", "nib_req", int'(nib_req),
          int'(mq.size() == 1));
    end
  end

  // R7: drive inputs only for the sampling bit time, junk otherwise
  task automatic put_nib(bit en, bit er, logic [3:0] d);
    @(negedge clk);
    while (mq.size() != 1) @(negedge clk);
    tx_en = en; tx_er = er; txd = d;
    do @(negedge clk); while (!m_loaded);
    tx_en = ~en; tx_er = ~er; txd = ~d;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(line_sym == 2'b00, "R1", "line_sym in reset", int'(line_sym), 0);
    chk(sym_stb == 1'b0, "R1", "sym_stb in reset", int'(sym_stb), 0);
    chk(nib_req == 1'b0, "R1", "nib_req in reset", int'(nib_req), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(line_sym == 2'b00 || sym_stb, "R1", "line_sym after reset", int'(line_sym), 0);

    cur_tag = "R2";
    repeat (12) put_nib(1'b0, 1'b0, 4'h0);
    cur_tag = "R3";
    put_nib(1'b1, 1'b0, 4'h5);
    put_nib(1'b0, 1'b1, 4'h2);
    cur_tag = "R4";
    for (int i = 0; i < 16; i++) put_nib(1'b1, 1'b0, i[3:0]);
    cur_tag = "R6";
    put_nib(1'b0, 1'b0, 4'h0);
    put_nib(1'b1, 1'b0, 4'hA);
    cur_tag = "R2";
    put_nib(1'b0, 1'b0, 4'h0);
    repeat (3) put_nib(1'b0, 1'b0, 4'h0);

    gap_mode = 1;
    cur_tag = "R5 R10";
    put_nib(1'b1, 1'b0, 4'h3);
    put_nib(1'b1, 1'b0, 4'h3);
    put_nib(1'b1, 1'b1, 4'h3);
    put_nib(1'b1, 1'b0, 4'h7);
    put_nib(1'b1, 1'b1, 4'hC);
    put_nib(1'b1, 1'b0, 4'h9);
    put_nib(1'b0, 1'b0, 4'h0);
    put_nib(1'b0, 1'b1, 4'h0);

    cur_tag = "R6 R3";
    put_nib(1'b1, 1'b0, 4'h5);
    put_nib(1'b1, 1'b0, 4'h1);
    put_nib(1'b1, 1'b0, 4'h2);
    put_nib(1'b0, 1'b0, 4'h0);
    put_nib(1'b1, 1'b0, 4'h0);
    put_nib(1'b1, 1'b0, 4'h5);
    put_nib(1'b1, 1'b0, 4'h5);
    put_nib(1'b1, 1'b0, 4'hE);
    put_nib(1'b0, 1'b0, 4'h0);
    put_nib(1'b0, 1'b0, 4'h0);

    gap_mode = 0;
    cur_tag = "R2";
    repeat (5) put_nib(1'b0, 1'b0, 4'h0);
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end
endmodule